// File: doc/BRIEF.md
# Masked circular operand address generator

This block produces the memory operand address for multiply-accumulate instructions. It also produces the updated address register value for the auto-update modes. When the instruction extension word enables masking, every generated address and every register update is ANDed with a 32-bit mask. The upper half of that mask is all ones and the lower half is a programmable 16-bit mask register. A power-of-two circular buffer therefore wraps by masking alone, with no compare or subtract.

The address path is purely combinational. An address register value, a two-bit mode, a 16-bit displacement and the enable bit come in, and an operand address, a next register value and a write-back strobe come out in the same cycle. The mask register has two write paths: a user port, and a debug command port that decodes an 8-bit command code.

Top module: `masq_agen`

## Requirements
- R1: After a synchronous reset the mask register reads 16'hFFFF, so a masked access returns the address register unchanged.
- R2: With `ext_mask_en` = 0, no AND is applied. Register-indirect gives `areg_in`. Post-increment gives address `areg_in` and next value `areg_in+4`. Pre-decrement gives `areg_in-4` for both the address and the next value. Displacement gives `areg_in` plus the sign-extended displacement.
- R3: The effective mask is {16'hFFFF, mask}. Masking never alters bits 31:16 of a generated value.
- R4: In register-indirect mode (`amode` = 2'd0) with masking enabled, `opnd_addr` = `areg_in` & effective mask.
- R5: In post-increment mode (`amode` = 2'd1) with masking enabled, `opnd_addr` = `areg_in` & mask and `areg_next` = (`areg_in`+4) & mask.
- R6: In pre-decrement mode (`amode` = 2'd2) with masking enabled, `opnd_addr` and `areg_next` both equal (`areg_in`-4) & mask.
- R7: In displacement mode (`amode` = 2'd3), `opnd_addr` = (`areg_in` + sign-extended `disp_in`) & mask, and the register is not updated.
- R8: `areg_wb` is 1 exactly in the post-increment and pre-decrement modes.
- R9: A user write (`usr_wr_en` = 1) loads `usr_wr_data` into the mask at the next clock edge, and `usr_rd_data` always shows the mask.
- R10: On the debug port, command 8'hC5 writes `dbg_wr_data[15:0]` into the mask. Command 8'hE5 returns {16'h0, mask} on `dbg_rd_data`, and `dbg_mask_sel` is 1 for these two codes only. Codes 8'hC6 and 8'hE6 belong to the accumulator: they leave the mask unchanged, and `dbg_rd_data` reads 0 for them.
- R11: When a debug write and a user write to the mask occur in the same cycle, the debug value is stored.
- R12: Address sums and differences wrap modulo 2^32 before masking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| usr_wr_en | input | 1 | User write strobe for the mask |
| usr_wr_data | input | 16 | User write value |
| usr_rd_data | output | 16 | Current mask value |
| dbg_cmd_valid | input | 1 | Debug command present |
| dbg_cmd | input | 8 | Debug command code |
| dbg_wr_data | input | 32 | Debug write value |
| dbg_rd_data | output | 32 | Debug read value |
| dbg_mask_sel | output | 1 | Debug command addresses the mask |
| areg_in | input | 32 | Address register value |
| amode | input | 2 | 0 indirect, 1 post-increment, 2 pre-decrement, 3 displacement |
| disp_in | input | 16 | Signed displacement |
| ext_mask_en | input | 1 | Extension-word mask enable |
| opnd_addr | output | 32 | Operand address |
| areg_next | output | 32 | Updated address register value |
| areg_wb | output | 1 | Address register write-back strobe |

## Verification
On every cycle the assertions check four things. The write-back strobe must match the mode. Masked indirect addresses must agree with the mask shown at the user port, and the upper half must pass through. Mask writes must land one edge later, with debug winning over user and accumulator codes leaving the mask alone. The bench scenarios cover the arithmetic: buffer wrap at the mask boundary in each auto-update mode, negative displacements, wrap past 2^32, and the unmasked results when the enable bit is clear.

// File: rtl/masq_pkg.sv
package masq_pkg;
    parameter int ADDR_W = 32;
    parameter int MASK_W = 16;
    parameter int DISP_W = 16;
    parameter int STEP   = 4;

    typedef enum logic [1:0] {
        AM_IND  = 2'd0,
        AM_POST = 2'd1,
        AM_PRE  = 2'd2,
        AM_DISP = 2'd3
    } amode_e;

    localparam logic [7:0] DBG_MASK_RD = 8'hE5;
    localparam logic [7:0] DBG_MASK_WR = 8'hC5;
    localparam logic [7:0] DBG_ACC_RD  = 8'hE6;
    localparam logic [7:0] DBG_ACC_WR  = 8'hC6;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] next;
        logic              wb;
    } agen_res_t;

    function automatic logic [ADDR_W-1:0] eff_mask(input logic en, input logic [MASK_W-1:0] m);
        if (en) return {{(ADDR_W-MASK_W){1'b1}}, m};
        return '1;
    endfunction

    function automatic logic [ADDR_W-1:0] sext_disp(input logic [DISP_W-1:0] d);
        return {{(ADDR_W-DISP_W){d[DISP_W-1]}}, d};
    endfunction
endpackage

// File: rtl/masq_dbg_decode.sv
module masq_dbg_decode
    import masq_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [7:0] cmd,
    output logic       mask_wr,
    output logic       mask_rd
);
    always_comb begin
        mask_wr = cmd_valid && (cmd == DBG_MASK_WR);
        mask_rd = cmd_valid && (cmd == DBG_MASK_RD);
    end
endmodule

// File: rtl/masq_mask_reg.sv
module masq_mask_reg
    import masq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              usr_we,
    input  logic [MASK_W-1:0] usr_wd,
    input  logic              dbg_we,
    input  logic [MASK_W-1:0] dbg_wd,
    output logic [MASK_W-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (rst)         mask_q <= '1;
        else if (dbg_we) mask_q <= dbg_wd;
        else if (usr_we) mask_q <= usr_wd;
    end
endmodule

// File: rtl/masq_addr_calc.sv
module masq_addr_calc
    import masq_pkg::*;
(
    input  logic [ADDR_W-1:0] areg,
    input  logic [1:0]        mode,
    input  logic [DISP_W-1:0] disp,
    input  logic              en,
    input  logic [MASK_W-1:0] mask,
    output agen_res_t         res
);
    logic [ADDR_W-1:0] m, s_inc, s_dec, s_disp;

    always_comb begin
        m      = eff_mask(en, mask);
        s_inc  = areg + ADDR_W'(STEP);
        s_dec  = areg - ADDR_W'(STEP);
        s_disp = areg + sext_disp(disp);
        res    = '0;
        unique case (amode_e'(mode))
            AM_IND: begin
                res.addr = areg & m;
                res.next = areg;
            end
            AM_POST: begin
                res.addr = areg & m;
                res.next = s_inc & m;
                res.wb   = 1'b1;
            end
            AM_PRE: begin
                res.addr = s_dec & m;
                res.next = s_dec & m;
                res.wb   = 1'b1;
            end
            default: begin
                res.addr = s_disp & m;
                res.next = areg;
            end
        endcase
    end
endmodule

// File: rtl/masq_agen.sv
module masq_agen
    import masq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              usr_wr_en,
    input  logic [MASK_W-1:0] usr_wr_data,
    output logic [MASK_W-1:0] usr_rd_data,
    input  logic              dbg_cmd_valid,
    input  logic [7:0]        dbg_cmd,
    input  logic [ADDR_W-1:0] dbg_wr_data,
    output logic [ADDR_W-1:0] dbg_rd_data,
    output logic              dbg_mask_sel,
    input  logic [ADDR_W-1:0] areg_in,
    input  logic [1:0]        amode,
    input  logic [DISP_W-1:0] disp_in,
    input  logic              ext_mask_en,
    output logic [ADDR_W-1:0] opnd_addr,
    output logic [ADDR_W-1:0] areg_next,
    output logic              areg_wb
);
    logic              d_wr, d_rd;
    logic [MASK_W-1:0] mask_q;
    agen_res_t         res;

    masq_dbg_decode u_dec (
        .cmd_valid(dbg_cmd_valid),
        .cmd      (dbg_cmd),
        .mask_wr  (d_wr),
        .mask_rd  (d_rd)
    );

    masq_mask_reg u_mask (
        .clk   (clk),
        .rst   (rst),
        .usr_we(usr_wr_en),
        .usr_wd(usr_wr_data),
        .dbg_we(d_wr),
        .dbg_wd(dbg_wr_data[MASK_W-1:0]),
        .mask_q(mask_q)
    );

    masq_addr_calc u_calc (
        .areg(areg_in),
        .mode(amode),
        .disp(disp_in),
        .en  (ext_mask_en),
        .mask(mask_q),
        .res (res)
    );

    always_comb begin
        usr_rd_data  = mask_q;
        dbg_mask_sel = d_wr | d_rd;
        dbg_rd_data  = d_rd ? {{(ADDR_W-MASK_W){1'b0}}, mask_q} : '0;
        opnd_addr    = res.addr;
        areg_next    = res.next;
        areg_wb      = res.wb;
    end
endmodule

// File: rtl/masq_agen_chk.sv
module masq_agen_chk
    import masq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              usr_wr_en,
    input logic [MASK_W-1:0] usr_wr_data,
    input logic [MASK_W-1:0] usr_rd_data,
    input logic              dbg_cmd_valid,
    input logic [7:0]        dbg_cmd,
    input logic [ADDR_W-1:0] dbg_wr_data,
    input logic [ADDR_W-1:0] dbg_rd_data,
    input logic              dbg_mask_sel,
    input logic [ADDR_W-1:0] areg_in,
    input logic [1:0]        amode,
    input logic [DISP_W-1:0] disp_in,
    input logic              ext_mask_en,
    input logic [ADDR_W-1:0] opnd_addr,
    input logic [ADDR_W-1:0] areg_next,
    input logic              areg_wb
);
    // R1
    reset_mask_chk: assert property (@(posedge clk) rst |=> usr_rd_data == '1);

    // R8
    wb_mode_chk: assert property (@(posedge clk) disable iff (rst)
        areg_wb == (amode == AM_POST || amode == AM_PRE));

    // R4
    ind_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (amode == AM_IND && ext_mask_en) |->
        opnd_addr == (areg_in & {{(ADDR_W-MASK_W){1'b1}}, usr_rd_data}));

    // R3
    upper_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (amode == AM_IND) |-> opnd_addr[ADDR_W-1:MASK_W] == areg_in[ADDR_W-1:MASK_W]);

    // R2
    nomask_ind_chk: assert property (@(posedge clk) disable iff (rst)
        (amode == AM_IND && !ext_mask_en) |-> opnd_addr == areg_in);

    // R9
    usr_write_chk: assert property (@(posedge clk) disable iff (rst)
        (usr_wr_en && !(dbg_cmd_valid && dbg_cmd == DBG_MASK_WR)) |=>
        usr_rd_data == $past(usr_wr_data));

    // R11
    dbg_write_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_cmd_valid && dbg_cmd == DBG_MASK_WR) |=>
        usr_rd_data == $past(dbg_wr_data[MASK_W-1:0]));

    // R10
    acc_nochg_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_cmd_valid && (dbg_cmd == DBG_ACC_WR || dbg_cmd == DBG_ACC_RD) && !usr_wr_en) |=>
        $stable(usr_rd_data));
endmodule

bind masq_agen masq_agen_chk u_chk (.*);

// File: tb/tb_masq_agen.sv
module tb_masq_agen;
    logic        clk = 1'b0;
    logic        rst;
    logic        usr_wr_en;
    logic [15:0] usr_wr_data;
    logic [15:0] usr_rd_data;
    logic        dbg_cmd_valid;
    logic [7:0]  dbg_cmd;
    logic [31:0] dbg_wr_data;
    logic [31:0] dbg_rd_data;
    logic        dbg_mask_sel;
    logic [31:0] areg_in;
    logic [1:0]  amode;
    logic [15:0] disp_in;
    logic        ext_mask_en;
    logic [31:0] opnd_addr;
    logic [31:0] areg_next;
    logic        areg_wb;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    masq_agen dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [1:0] m, input logic [15:0] d, input logic en);
        @(negedge clk);
        areg_in = a; amode = m; disp_in = d; ext_mask_en = en;
        #1;
    endtask

    task automatic user_wr(input logic [15:0] v);
        @(negedge clk);
        usr_wr_en = 1'b1; usr_wr_data = v;
        @(negedge clk);
        usr_wr_en = 1'b0;
    endtask

    task automatic dbg_op(input logic [7:0] c, input logic [31:0] v);
        @(negedge clk);
        dbg_cmd_valid = 1'b1; dbg_cmd = c; dbg_wr_data = v;
        #1;
    endtask

    task automatic dbg_idle();
        @(negedge clk);
        dbg_cmd_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 mask", {16'h0, usr_rd_data}, 32'h0000FFFF);
        apply(32'h12345678, 2'd0, 16'h0, 1'b1);
        chk("R1 addr", opnd_addr, 32'h12345678);
    endtask

    task automatic t_nomask();
        user_wr(16'h00FF);
        chk("R9 readback", {16'h0, usr_rd_data}, 32'h000000FF);
        apply(32'hA0001234, 2'd0, 16'h0, 1'b0);
        chk("R2 ind", opnd_addr, 32'hA0001234);
        chk("R8 ind wb", {31'h0, areg_wb}, 32'h0);
        apply(32'hA0001234, 2'd1, 16'h0, 1'b0);
        chk("R2 post addr", opnd_addr, 32'hA0001234);
        chk("R2 post next", areg_next, 32'hA0001238);
        chk("R8 post wb", {31'h0, areg_wb}, 32'h1);
        apply(32'hA0001234, 2'd2, 16'h0, 1'b0);
        chk("R2 pre addr", opnd_addr, 32'hA0001230);
        chk("R2 pre next", areg_next, 32'hA0001230);
        apply(32'hA0001234, 2'd3, 16'hFFF0, 1'b0);
        chk("R2 disp", opnd_addr, 32'hA0001224);
    endtask

    task automatic t_masked();
        apply(32'hA00012FC, 2'd0, 16'h0, 1'b1);
        chk("R4 ind", opnd_addr, 32'hA00000FC);
        chk("R3 upper", {16'h0, opnd_addr[31:16]}, 32'h0000A000);
        apply(32'hA00012FC, 2'd1, 16'h0, 1'b1);
        chk("R5 post addr", opnd_addr, 32'hA00000FC);
        chk("R5 post next", areg_next, 32'hA0000000);
        apply(32'hA0001200, 2'd2, 16'h0, 1'b1);
        chk("R6 pre addr", opnd_addr, 32'hA00000FC);
        chk("R6 pre next", areg_next, 32'hA00000FC);
        chk("R8 pre wb", {31'h0, areg_wb}, 32'h1);
        apply(32'hA00012F0, 2'd3, 16'h0020, 1'b1);
        chk("R7 disp pos", opnd_addr, 32'hA0000010);
        chk("R7 disp wb", {31'h0, areg_wb}, 32'h0);
        apply(32'hA00012F0, 2'd3, 16'hFFE0, 1'b1);
        chk("R7 disp neg", opnd_addr, 32'hA00000D0);
    endtask

    task automatic t_wrap();
        user_wr(16'hFFFF);
        apply(32'hFFFFFFFE, 2'd1, 16'h0, 1'b1);
        chk("R12 post", areg_next, 32'h00000002);
        apply(32'h00000002, 2'd2, 16'h0, 1'b1);
        chk("R12 pre", opnd_addr, 32'hFFFFFFFE);
        apply(32'hFFFFFFF0, 2'd3, 16'h0020, 1'b1);
        chk("R12 disp", opnd_addr, 32'h00000010);
    endtask

    task automatic t_debug();
        dbg_op(8'hC5, 32'hABCD1234);
        chk("R10 wr sel", {31'h0, dbg_mask_sel}, 32'h1);
        dbg_idle();
        chk("R10 wr", {16'h0, usr_rd_data}, 32'h00001234);
        dbg_op(8'hE5, 32'h0);
        chk("R10 rd", dbg_rd_data, 32'h00001234);
        chk("R10 rd sel", {31'h0, dbg_mask_sel}, 32'h1);
        dbg_op(8'hC6, 32'h00005555);
        chk("R10 acc sel", {31'h0, dbg_mask_sel}, 32'h0);
        dbg_idle();
        chk("R10 acc wr", {16'h0, usr_rd_data}, 32'h00001234);
        dbg_op(8'hE6, 32'h0);
        chk("R10 acc rd", dbg_rd_data, 32'h0);
        dbg_idle();
    endtask

    task automatic t_priority();
        @(negedge clk);
        usr_wr_en = 1'b1; usr_wr_data = 16'h1111;
        dbg_cmd_valid = 1'b1; dbg_cmd = 8'hC5; dbg_wr_data = 32'h00002222;
        @(negedge clk);
        usr_wr_en = 1'b0; dbg_cmd_valid = 1'b0;
        chk("R11 dbg wins", {16'h0, usr_rd_data}, 32'h00002222);
        user_wr(16'h3333);
        chk("R9 user", {16'h0, usr_rd_data}, 32'h00003333);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; usr_wr_en = 1'b0; usr_wr_data = '0;
        dbg_cmd_valid = 1'b0; dbg_cmd = '0; dbg_wr_data = '0;
        areg_in = '0; amode = '0; disp_in = '0; ext_mask_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_nomask();
        t_masked();
        t_wrap();
        t_debug();
        t_priority();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule